// File: doc/BRIEF.md
# Host/Controller Mailbox Byte Buffers

This block holds the two byte buffers of a host-to-management-controller mailbox. The request buffer carries command bytes from the host to the controller. The response buffer carries reply bytes the other way. The host reaches both buffers through one data offset in a small I/O window. A host write at that offset appends a byte to the request buffer. A host read at that offset takes the next byte from the response buffer. On the controller side this is reversed: a push appends to the response buffer and a pop drains the request buffer.

Each buffer is linear rather than circular. Its write pointer and its read pointer each start at zero and count up. Either pointer returns to the start only through an explicit clear strobe; there is no full or empty flow control. The host issues its two clear strobes by writing to the control offset of the window. The controller has dedicated clear inputs. The buffer depth is a parameter (at least 64) and is reported on an output so that capacity can be told to software.

Top module: `mbox_buffers`

## Requirements
- R1: After reset every pointer is 0 and both buffers are empty. A host read at offset 1 returns 0x00 and `ctlRdata` is 0x00.
- R2: A host write (`hostCs`=1, `hostWr`=1, `hostAddr`=1) appends `hostWdata` to the request buffer. `ctlRdata` shows the oldest unread request byte, and each `ctlPop` advances to the next byte in write order.
- R3: A `ctlPush` appends `ctlWdata` to the response buffer. A host read (`hostCs`=1, `hostRd`=1, `hostAddr`=1) returns the oldest unread response byte on `hostRdata` in that same cycle, and the read pointer advances at the clock edge.
- R4: A read when the read pointer has caught up with the write pointer returns 0x00 and leaves the read pointer where it is. A byte written afterwards is the next one read.
- R5: A write to a buffer that already holds DEPTH bytes since its last write-pointer clear is dropped.
- R6: A host write at offset 0 clears pointers according to its data bits. Bit 0 set moves the request write pointer to the start. Bit 1 set moves the response read pointer to the start. A data bit of 0 has no effect.
- R7: `ctlClrWr` moves the response write pointer to the start. `ctlClrRd` moves the request read pointer to the start.
- R8: A clear strobe wins over a push or pop on the same pointer in the same cycle. The clear is applied and the push or pop is discarded.
- R9: With `hostCs` low, or at offsets 2 and 3, host accesses leave both buffers untouched. A host read at offset 0 also leaves both buffers untouched. `hostRdata` is 0x00 except during a host read at offset 1.
- R10: `capacity` always equals the DEPTH parameter.
- R11: A push on one side and a pop on the other side of the same buffer in one cycle both take effect. The pop sees the contents as they were before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCs | input | 1 | Host window select |
| hostAddr | input | 2 | Host offset (0 control, 1 data, 2-3 not decoded here) |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data from the response buffer |
| ctlPush | input | 1 | Controller append to the response buffer |
| ctlWdata | input | 8 | Controller write data |
| ctlPop | input | 1 | Controller advance through the request buffer |
| ctlRdata | output | 8 | Oldest unread request byte, or 0x00 |
| ctlClrWr | input | 1 | Clear the response write pointer |
| ctlClrRd | input | 1 | Clear the request read pointer |
| capacity | output | 7 | Buffer depth in bytes |

## Verification
Two functions can fall in the same cycle on one buffer: a push from one side and a pop from the other. So can a clear strobe and the push or pop it overrides. The bench provokes the first case by driving a host data write together with a controller pop, once with the request buffer empty and once with it holding data. It also drives a controller push together with a host read on an empty response buffer. In each case it judges the byte seen in that cycle against the contents before the edge, and the byte seen next against the new contents. For clear collisions, the bench drives a clear with a push or pop in one cycle. It then reads back through the normal ports to confirm that the pointer restarted at zero and that the pushed byte never appeared.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W = 8;
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam int CLR_WR_BIT = 0;
  localparam int CLR_RD_BIT = 1;

  typedef struct packed {
    logic reqPush;
    logic reqPop;
    logic reqClrWr;
    logic reqClrRd;
    logic rspPush;
    logic rspPop;
    logic rspClrWr;
    logic rspClrRd;
    logic hostRdSel;
  } laneStrobes_t;
endpackage

// File: rtl/mbox_lane.sv
module mbox_lane #(
  parameter int DEPTH = 64,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              clrWr,
  input  logic              clrRd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] headData,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr
);
  localparam logic [PTR_W-1:0] FULL_MARK = PTR_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic pushOk;
  logic popOk;
  logic hasData;

  assign hasData = rdPtr < wrPtr;
  assign pushOk  = push && !clrWr && (wrPtr < FULL_MARK);
  assign popOk   = pop && !clrRd && hasData;

  always_ff @(posedge clk) begin
    if (pushOk) store[wrPtr[IDX_W-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (clrWr) begin
      wrPtr <= '0;
    end else if (pushOk) begin
      wrPtr <= wrPtr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (clrRd) begin
      rdPtr <= '0;
    end else if (popOk) begin
      rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  always_comb begin
    headData = '0;
    if (hasData) headData = store[rdPtr[IDX_W-1:0]];
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic         hostCs,
  input  logic [1:0]   hostAddr,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic [1:0]   hostClrBits,
  input  logic         ctlPush,
  input  logic         ctlPop,
  input  logic         ctlClrWr,
  input  logic         ctlClrRd,
  output laneStrobes_t strb
);
  logic hostDataWr;
  logic hostDataRd;
  logic hostCtrlWr;

  assign hostDataWr = hostCs && hostWr && (hostAddr == OFS_DATA);
  assign hostDataRd = hostCs && hostRd && !hostWr && (hostAddr == OFS_DATA);
  assign hostCtrlWr = hostCs && hostWr && (hostAddr == OFS_CTRL);

  always_comb begin
    strb           = '0;
    strb.reqPush   = hostDataWr;
    strb.reqPop    = ctlPop;
    strb.reqClrWr  = hostCtrlWr && hostClrBits[CLR_WR_BIT];
    strb.reqClrRd  = ctlClrRd;
    strb.rspPush   = ctlPush;
    strb.rspPop    = hostDataRd;
    strb.rspClrWr  = ctlClrWr;
    strb.rspClrRd  = hostCtrlWr && hostClrBits[CLR_RD_BIT];
    strb.hostRdSel = hostDataRd;
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobes_t      strb,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] ctlWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] ctlRdata,
  output logic [PTR_W-1:0]  reqWrPtr,
  output logic [PTR_W-1:0]  reqRdPtr,
  output logic [PTR_W-1:0]  rspWrPtr,
  output logic [PTR_W-1:0]  rspRdPtr
);
  logic [DATA_W-1:0] rspHead;

  mbox_lane #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_reqLane (
    .clk(clk), .rstN(rstN),
    .push(strb.reqPush), .pop(strb.reqPop),
    .clrWr(strb.reqClrWr), .clrRd(strb.reqClrRd),
    .wdata(hostWdata), .headData(ctlRdata),
    .wrPtr(reqWrPtr), .rdPtr(reqRdPtr)
  );

  mbox_lane #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_rspLane (
    .clk(clk), .rstN(rstN),
    .push(strb.rspPush), .pop(strb.rspPop),
    .clrWr(strb.rspClrWr), .clrRd(strb.rspClrRd),
    .wdata(ctlWdata), .headData(rspHead),
    .wrPtr(rspWrPtr), .rdPtr(rspRdPtr)
  );

  assign hostRdata = strb.hostRdSel ? rspHead : '0;
endmodule

// File: rtl/mbox_buffers.sv
module mbox_buffers
  import mbox_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCs,
  input  logic [1:0]        hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              ctlPush,
  input  logic [DATA_W-1:0] ctlWdata,
  input  logic              ctlPop,
  output logic [DATA_W-1:0] ctlRdata,
  input  logic              ctlClrWr,
  input  logic              ctlClrRd,
  output logic [PTR_W-1:0]  capacity
);
  laneStrobes_t strb;
  logic [PTR_W-1:0] reqWrPtr;
  logic [PTR_W-1:0] reqRdPtr;
  logic [PTR_W-1:0] rspWrPtr;
  logic [PTR_W-1:0] rspRdPtr;

  initial begin
    if (DEPTH < 64) $error("mbox_buffers: DEPTH must be at least 64");
  end

  mbox_ctrl i_ctrl (
    .hostCs(hostCs), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostClrBits(hostWdata[1:0]),
    .ctlPush(ctlPush), .ctlPop(ctlPop),
    .ctlClrWr(ctlClrWr), .ctlClrRd(ctlClrRd),
    .strb(strb)
  );

  mbox_datapath #(.DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostWdata(hostWdata), .ctlWdata(ctlWdata),
    .hostRdata(hostRdata), .ctlRdata(ctlRdata),
    .reqWrPtr(reqWrPtr), .reqRdPtr(reqRdPtr),
    .rspWrPtr(rspWrPtr), .rspRdPtr(rspRdPtr)
  );

  assign capacity = PTR_W'(DEPTH);
endmodule

// File: rtl/mbox_buffers_chk.sv
module mbox_buffers_chk #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostCs,
  input logic [1:0]       hostAddr,
  input logic             hostWr,
  input logic             hostRd,
  input logic             ctlPush,
  input logic             ctlPop,
  input logic             ctlClrWr,
  input logic             ctlClrRd,
  input logic [7:0]       ctlRdata,
  input logic [PTR_W-1:0] reqWrPtr,
  input logic [PTR_W-1:0] reqRdPtr,
  input logic [PTR_W-1:0] rspWrPtr,
  input logic [PTR_W-1:0] rspRdPtr
);
  localparam logic [PTR_W-1:0] FULL_MARK = PTR_W'(DEPTH);

  logic hostDataWr;
  assign hostDataWr = hostCs && hostWr && (hostAddr == 2'd1);

  assert_host_push_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostDataWr && reqWrPtr < FULL_MARK) |=> reqWrPtr == PTR_W'($past(reqWrPtr) + 1'b1));

  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqRdPtr >= reqWrPtr) |-> ctlRdata == 8'h00);

  assert_empty_pop_still_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlPop && !ctlClrRd && reqRdPtr >= reqWrPtr) |=> reqRdPtr == $past(reqRdPtr));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqWrPtr <= FULL_MARK) && (rspWrPtr <= FULL_MARK));

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostDataWr && reqWrPtr == FULL_MARK) |=> reqWrPtr == FULL_MARK);

  assert_ctl_clear_wr_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctlClrWr |=> rspWrPtr == '0);

  assert_clear_beats_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctlClrRd && ctlPop) |=> reqRdPtr == '0);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!hostCs && !ctlPush && !ctlPop && !ctlClrWr && !ctlClrRd) |=>
      ($stable(reqWrPtr) && $stable(reqRdPtr) && $stable(rspWrPtr) && $stable(rspRdPtr)));
endmodule

bind mbox_buffers mbox_buffers_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .hostCs(hostCs), .hostAddr(hostAddr),
  .hostWr(hostWr), .hostRd(hostRd), .ctlPush(ctlPush), .ctlPop(ctlPop),
  .ctlClrWr(ctlClrWr), .ctlClrRd(ctlClrRd), .ctlRdata(ctlRdata),
  .reqWrPtr(reqWrPtr), .reqRdPtr(reqRdPtr),
  .rspWrPtr(rspWrPtr), .rspRdPtr(rspRdPtr)
);

// File: tb/test_mbox_buffers.sv
module test_mbox_buffers;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int PTR_W = $clog2(DEPTH + 1);

  logic clk = 0;
  logic rstN = 0;
  logic hostCs = 0;
  logic [1:0] hostAddr = 0;
  logic hostWr = 0;
  logic hostRd = 0;
  logic [7:0] hostWdata = 0;
  logic [7:0] hostRdata;
  logic ctlPush = 0;
  logic [7:0] ctlWdata = 0;
  logic ctlPop = 0;
  logic [7:0] ctlRdata;
  logic ctlClrWr = 0;
  logic ctlClrRd = 0;
  logic [PTR_W-1:0] capacity;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_buffers #(.DEPTH(DEPTH)) i_mbox_buffers (
    .clk(clk), .rstN(rstN), .hostCs(hostCs), .hostAddr(hostAddr),
    .hostWr(hostWr), .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .ctlPush(ctlPush), .ctlWdata(ctlWdata), .ctlPop(ctlPop), .ctlRdata(ctlRdata),
    .ctlClrWr(ctlClrWr), .ctlClrRd(ctlClrRd), .capacity(capacity)
  );

  function automatic logic [7:0] reqPat(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction
  function automatic logic [7:0] rspPat(int i);
    return 8'((i * 91 + 200) & 255);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic cs, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    hostCs = cs; hostAddr = a; hostWr = 1; hostWdata = d;
    @(negedge clk);
    hostCs = 0; hostWr = 0;
  endtask

  task automatic hostRead(logic cs, logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostCs = cs; hostAddr = a; hostRd = 1;
    #1 d = hostRdata;
    @(negedge clk);
    hostCs = 0; hostRd = 0;
  endtask

  task automatic ctlPushByte(logic [7:0] d);
    @(negedge clk);
    ctlPush = 1; ctlWdata = d;
    @(negedge clk);
    ctlPush = 0;
  endtask

  task automatic ctlPopByte(output logic [7:0] d);
    @(negedge clk);
    ctlPop = 1;
    #1 d = ctlRdata;
    @(negedge clk);
    ctlPop = 0;
  endtask

  task automatic ctlStrobe(logic clrW, logic clrR);
    @(negedge clk);
    ctlClrWr = clrW; ctlClrRd = clrR;
    @(negedge clk);
    ctlClrWr = 0; ctlClrRd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state, R10 capacity
    hostRead(1, 2'd1, d); check("R1 host read after reset", d, 8'h00);
    #1 check("R1 ctlRdata after reset", ctlRdata, 8'h00);
    check("R10 capacity", 8'(capacity), 8'(DEPTH));

    // R2 fill request buffer, R5 overflow write dropped
    for (int i = 0; i < DEPTH; i++) hostWrite(1, 2'd1, reqPat(i));
    hostWrite(1, 2'd1, 8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      ctlPopByte(d); check("R2 request byte order", d, reqPat(i));
    end
    ctlPopByte(d); check("R5 overflow byte dropped / R4 empty", d, 8'h00);

    // R3 fill response buffer and drain from host
    for (int i = 0; i < DEPTH; i++) ctlPushByte(rspPat(i));
    ctlPushByte(8'hDD);
    for (int i = 0; i < DEPTH; i++) begin
      hostRead(1, 2'd1, d); check("R3 response byte order", d, rspPat(i));
    end
    hostRead(1, 2'd1, d); check("R4 read past data", d, 8'h00);

    // R6 host clear read pointer of response buffer, zero bit no effect
    hostWrite(1, 2'd0, 8'h02);
    hostRead(1, 2'd1, d); check("R6 reread byte 0", d, rspPat(0));
    hostRead(1, 2'd1, d); check("R6 reread byte 1", d, rspPat(1));
    hostWrite(1, 2'd0, 8'h00);
    hostRead(1, 2'd1, d); check("R6 zero write no effect", d, rspPat(2));

    // R6 host clear write ptr, R7 ctl clear read ptr, R4 pointer holds
    hostWrite(1, 2'd0, 8'h01);
    ctlStrobe(0, 1);
    ctlPopByte(d); check("R4 empty pop returns zero", d, 8'h00);
    ctlPopByte(d); check("R4 empty pop again", d, 8'h00);
    hostWrite(1, 2'd1, 8'h5A);
    #1 check("R6 R7 request restarts at zero", ctlRdata, 8'h5A);

    // R7 ctl clear write pointer of response buffer
    ctlStrobe(1, 0);
    ctlPushByte(8'h11);
    hostWrite(1, 2'd0, 8'h02);
    hostRead(1, 2'd1, d); check("R7 response restarts at zero", d, 8'h11);
    hostRead(1, 2'd1, d); check("R7 only one byte present", d, 8'h00);

    // R8 clear wins over push
    @(negedge clk); ctlPush = 1; ctlWdata = 8'h77; ctlClrWr = 1;
    @(negedge clk); ctlPush = 0; ctlClrWr = 0;
    hostWrite(1, 2'd0, 8'h02);
    hostRead(1, 2'd1, d); check("R8 push dropped under clear", d, 8'h00);

    // R8 clear wins over pop: request holds 5A, 33
    ctlPopByte(d); check("R2 pop 5A", d, 8'h5A);
    hostWrite(1, 2'd1, 8'h33);
    @(negedge clk); ctlPop = 1; ctlClrRd = 1;
    @(negedge clk); ctlPop = 0; ctlClrRd = 0;
    #1 check("R8 read pointer at start", ctlRdata, 8'h5A);

    // R9 ignored host accesses
    ctlStrobe(1, 0);
    ctlPushByte(8'h44);
    hostWrite(1, 2'd0, 8'h02);
    hostWrite(0, 2'd1, 8'h99);
    hostWrite(1, 2'd2, 8'h98);
    hostWrite(1, 2'd3, 8'h97);
    hostRead(0, 2'd1, d); check("R9 cs low read", d, 8'h00);
    hostRead(1, 2'd0, d); check("R9 offset 0 read", d, 8'h00);
    hostRead(1, 2'd2, d); check("R9 offset 2 read", d, 8'h00);
    hostRead(1, 2'd3, d); check("R9 offset 3 read", d, 8'h00);
    hostRead(1, 2'd1, d); check("R9 response untouched", d, 8'h44);
    ctlPopByte(d); check("R9 request byte 0", d, 8'h5A);
    ctlPopByte(d); check("R9 request byte 1", d, 8'h33);
    ctlPopByte(d); check("R9 no stray request byte", d, 8'h00);

    // R11 same-cycle host push + ctl pop on empty request buffer
    @(negedge clk);
    hostCs = 1; hostAddr = 2'd1; hostWr = 1; hostWdata = 8'h62; ctlPop = 1;
    #1 check("R11 pop sees empty before edge", ctlRdata, 8'h00);
    @(negedge clk);
    hostCs = 0; hostWr = 0; ctlPop = 0;
    #1 check("R11 pushed byte now head", ctlRdata, 8'h62);
    // non-empty: push 63 while popping 62
    @(negedge clk);
    hostCs = 1; hostAddr = 2'd1; hostWr = 1; hostWdata = 8'h63; ctlPop = 1;
    #1 check("R11 pop sees old head", ctlRdata, 8'h62);
    @(negedge clk);
    hostCs = 0; hostWr = 0; ctlPop = 0;
    #1 check("R11 next head after both", ctlRdata, 8'h63);

    // R11 ctl push with host read on empty response buffer
    ctlStrobe(1, 0);
    hostWrite(1, 2'd0, 8'h02);
    @(negedge clk);
    ctlPush = 1; ctlWdata = 8'h21; hostCs = 1; hostAddr = 2'd1; hostRd = 1;
    #1 check("R11 host read sees empty", hostRdata, 8'h00);
    @(negedge clk);
    ctlPush = 0; hostCs = 0; hostRd = 0;
    hostRead(1, 2'd1, d); check("R11 host then reads pushed byte", d, 8'h21);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule